// File: doc/BRIEF.md
# Miss-Driven Supply Mode Controller

This controller picks the operating point of a processor core. In the fast mode the core runs from the high supply at full clock rate. In the saving mode it runs from the low supply at half clock rate. When the core reports a last-level cache miss, the controller watches how many instructions issue over a short window. If too few issue, the core is stalled on memory anyway, so the controller halves the clock and then lowers the supply.

While the core sits in the saving mode, the controller waits for the final outstanding miss to come back. It then watches issue activity over a second window. If enough instructions issue, it raises the supply while the clock stays halved, and it restores the full clock only when the ramp is complete. A busy flag covers both supply ramps. No new mode change can begin while a ramp is running. The regulator and the clock generator sit outside the block and follow its select outputs.

Top module: `vmode_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the controller is in the fast mode with `supply_low`=0, `clk_half`=0 and `busy`=0.
- R2: A `miss_det` pulse seen in the fast mode opens a down window of `DOWN_WIN` cycles that starts in the next cycle and sums `issue_cnt` over every cycle of the window. The outputs stay at their fast-mode values throughout the window.
- R3: At the end of the down window, a sum no greater than `LOW_ILP_MAX` starts the down ramp in the next cycle. A larger sum returns the controller to the fast mode, with no output change.
- R4: The down ramp lasts `CLK_LEAD+RAMP_CYC` cycles with `busy`=1 and `clk_half`=1 from its first cycle. `supply_low` rises in ramp cycle `CLK_LEAD`, counting from 0. Afterwards the controller rests in the saving mode with `supply_low`=1, `clk_half`=1 and `busy`=0.
- R5: In the saving mode, an up window starts only in a cycle where `miss_ret`=1, `miss_outstanding`=1 (the count includes the miss now returning) and `miss_det`=0. A return with a count above 1 has no effect.
- R6: The up window lasts `UP_WIN` cycles and sums `issue_cnt`. A sum of at least `HIGH_ILP_MIN` starts the up ramp in the next cycle. Any smaller sum goes back to the saving mode. The outputs keep their saving-mode values during the window.
- R7: The up ramp lasts `RAMP_CYC` cycles with `supply_low`=0, `clk_half`=1 and `busy`=1. After it, the controller is in the fast mode with `clk_half`=0 and `busy`=0.
- R8: `miss_det` and `miss_ret` have no effect while either ramp is running. The ramp length and the output sequence stay unchanged.
- R9: A `miss_det` pulse during the up window abandons the window, and the controller returns to the saving mode in the next cycle.
- R10: `supply_low`=1 always implies `clk_half`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_det | input | 1 | One-cycle pulse: a last-level cache miss was detected |
| miss_ret | input | 1 | One-cycle pulse: a miss returned |
| miss_outstanding | input | MISS_W | Outstanding misses, including any returning this cycle |
| issue_cnt | input | ISSUE_W | Instructions issued this cycle |
| supply_low | output | 1 | 1 selects the low supply, 0 the high supply |
| clk_half | output | 1 | 1 selects the halved clock |
| busy | output | 1 | A supply ramp is in progress |

## Verification
The bench builds the block with `DOWN_WIN`=4, `UP_WIN`=6, `CLK_LEAD`=2, `RAMP_CYC`=5, `LOW_ILP_MAX`=4 and `HIGH_ILP_MIN`=12, with 3-bit issue and miss counts. The short windows and ramps let a few thousand random cycles pass through the full mode round trip many times. In random stimulus, a low-activity phase (0 or 1 issue per cycle) always passes the down check and always fails the up check, and a high-activity phase (2 to 7 per cycle) does the reverse, so both verdicts of each window are reached. Directed sequences hit the exact threshold sums, a return that is not the last, a detect and a return in the same cycle, an abort of the up window, and pulses sent during both ramps.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

    typedef enum logic [2:0] {
        ST_HIGH    = 3'd0,
        ST_DN_CHK  = 3'd1,
        ST_RAMP_DN = 3'd2,
        ST_LOW     = 3'd3,
        ST_UP_CHK  = 3'd4,
        ST_RAMP_UP = 3'd5
    } vmode_e;

    typedef struct packed {
        logic supply_low;
        logic clk_half;
        logic busy;
    } vmode_out_t;

    // Moore decode of the select outputs from the controller state.
    function automatic vmode_out_t mode_outputs(vmode_e st, logic lead_met);
        vmode_out_t o;
        o = '0;
        case (st)
            ST_RAMP_DN: begin
                o.clk_half   = 1'b1;
                o.busy       = 1'b1;
                o.supply_low = lead_met;
            end
            ST_LOW, ST_UP_CHK: begin
                o.clk_half   = 1'b1;
                o.supply_low = 1'b1;
            end
            ST_RAMP_UP: begin
                o.clk_half = 1'b1;
                o.busy     = 1'b1;
            end
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/vmode_ilp_window.sv
module vmode_ilp_window #(
    parameter int ISSUE_W   = 3,
    parameter int WIN       = 10,
    parameter int THR       = 10,
    parameter bit JUDGE_LOW = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic [ISSUE_W-1:0] issue_cnt,
    output logic               done,
    output logic               pass
);
    localparam int MAXSUM = WIN * ((1 << ISSUE_W) - 1);
    localparam int ACC_W  = $clog2(MAXSUM + 1) + 1;
    localparam int CNT_W  = $clog2(WIN + 1);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] total;
    logic [CNT_W-1:0] cnt;

    assign total = acc + ACC_W'(issue_cnt);
    assign done  = active && (cnt == CNT_W'(WIN - 1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            acc <= '0;
            cnt <= '0;
        end else begin
            acc <= total;
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (JUDGE_LOW) begin : g_judge_low
            assign pass = (total <= ACC_W'(THR));
        end else begin : g_judge_high
            assign pass = (total >= ACC_W'(THR));
        end
    endgenerate

    // R2/R6: the controller leaves a window no later than its last cycle
    a_r2_window_bounded: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < CNT_W'(WIN)));

endmodule

// File: rtl/vmode_ramp_timer.sv
module vmode_ramp_timer #(
    parameter int MAX_LEN = 16,
    localparam int PH_W   = $clog2(MAX_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    output logic [PH_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R8: a ramp ends on time, so the phase never reaches the longest length
    a_r8_phase_bounded: assert property (@(posedge clk) disable iff (rst)
        active |-> (phase < PH_W'(MAX_LEN)));

endmodule

// File: rtl/vmode_ctrl.sv
module vmode_ctrl #(
    parameter int ISSUE_W      = 3,
    parameter int MISS_W       = 4,
    parameter int DOWN_WIN     = 10,
    parameter int UP_WIN       = 20,
    parameter int CLK_LEAD     = 4,
    parameter int RAMP_CYC     = 12,
    parameter int LOW_ILP_MAX  = 10,
    parameter int HIGH_ILP_MIN = 30
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               miss_det,
    input  logic               miss_ret,
    input  logic [MISS_W-1:0]  miss_outstanding,
    input  logic [ISSUE_W-1:0] issue_cnt,
    output logic               supply_low,
    output logic               clk_half,
    output logic               busy
);
    import vmode_pkg::*;

    localparam int DN_LEN = CLK_LEAD + RAMP_CYC;
    localparam int PH_W   = $clog2(DN_LEN + 1);

    vmode_e          state, state_nx;
    logic            dn_done, dn_pass, up_done, up_pass;
    logic [PH_W-1:0] ramp_phase;
    logic            lead_met, last_return;
    vmode_out_t      outs;

    vmode_ilp_window #(
        .ISSUE_W(ISSUE_W), .WIN(DOWN_WIN), .THR(LOW_ILP_MAX), .JUDGE_LOW(1'b1)
    ) u_down_mon (
        .clk(clk), .rst(rst), .active(state == ST_DN_CHK),
        .issue_cnt(issue_cnt), .done(dn_done), .pass(dn_pass)
    );

    vmode_ilp_window #(
        .ISSUE_W(ISSUE_W), .WIN(UP_WIN), .THR(HIGH_ILP_MIN), .JUDGE_LOW(1'b0)
    ) u_up_mon (
        .clk(clk), .rst(rst), .active(state == ST_UP_CHK),
        .issue_cnt(issue_cnt), .done(up_done), .pass(up_pass)
    );

    vmode_ramp_timer #(
        .MAX_LEN(DN_LEN)
    ) u_ramp (
        .clk(clk), .rst(rst),
        .active((state == ST_RAMP_DN) || (state == ST_RAMP_UP)),
        .phase(ramp_phase)
    );

    assign lead_met    = (ramp_phase >= PH_W'(CLK_LEAD));
    assign last_return = miss_ret && !miss_det && (miss_outstanding == MISS_W'(1));

    always_comb begin
        state_nx = state;
        case (state)
            ST_HIGH:    if (miss_det) state_nx = ST_DN_CHK;
            ST_DN_CHK:  if (dn_done) state_nx = dn_pass ? ST_RAMP_DN : ST_HIGH;
            ST_RAMP_DN: if (ramp_phase == PH_W'(DN_LEN - 1)) state_nx = ST_LOW;
            ST_LOW:     if (last_return) state_nx = ST_UP_CHK;
            ST_UP_CHK: begin
                if (miss_det)     state_nx = ST_LOW;
                else if (up_done) state_nx = up_pass ? ST_RAMP_UP : ST_LOW;
            end
            ST_RAMP_UP: if (ramp_phase == PH_W'(RAMP_CYC - 1)) state_nx = ST_HIGH;
            default:    state_nx = ST_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HIGH;
        else     state <= state_nx;
    end

    assign outs       = mode_outputs(state, lead_met);
    assign supply_low = outs.supply_low;
    assign clk_half   = outs.clk_half;
    assign busy       = outs.busy;

    // R2: a down window is opened only by a detected miss
    a_r2_down_trigger: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DN_CHK && $past(state) == ST_HIGH) |-> $past(miss_det));

    // R4: the clock is already halved before the low supply is selected
    a_r4_clock_first: assert property (@(posedge clk) disable iff (rst)
        $rose(supply_low) |-> (clk_half && $past(clk_half)));

    // R5: an up window is opened only by the last returning miss
    a_r5_up_trigger: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UP_CHK && $past(state) == ST_LOW)
            |-> ($past(miss_ret) && !$past(miss_det) && $past(miss_outstanding) == MISS_W'(1)));

    // R7: full clock returns only after a ramp, on the high supply
    a_r7_full_clock_last: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_half) |-> (!supply_low && $past(busy)));

    // R8: no other transition can interrupt either ramp
    a_r8_ramp_dn_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RAMP_DN) |=> (state == ST_RAMP_DN || state == ST_LOW));
    a_r8_ramp_up_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RAMP_UP) |=> (state == ST_RAMP_UP || state == ST_HIGH));

    // R9: a new miss abandons the up window
    a_r9_abort: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UP_CHK && miss_det) |=> (state == ST_LOW));

    // R10: low supply never runs with the full clock
    a_r10_low_needs_half: assert property (@(posedge clk) disable iff (rst)
        supply_low |-> clk_half);

endmodule

// File: tb/vmode_ctrl_test.sv
module vmode_ctrl_test;
    localparam int ISSUE_W = 3;
    localparam int MISS_W  = 3;
    localparam int DW      = 4;
    localparam int UW      = 6;
    localparam int LEAD    = 2;
    localparam int RAMP    = 5;
    localparam int LT      = 4;
    localparam int HT      = 12;

    localparam int M_HIGH = 0, M_DN = 1, M_RD = 2, M_LOW = 3, M_UC = 4, M_RU = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic miss_det = 1'b0, miss_ret = 1'b0;
    logic [MISS_W-1:0]  miss_outstanding = '0;
    logic [ISSUE_W-1:0] issue_cnt = '0;
    logic supply_low, clk_half, busy;

    int errs = 0, checks = 0;
    int m_st = M_HIGH, m_cnt = 0, m_acc = 0;

    always #10 clk = ~clk;

    vmode_ctrl #(
        .ISSUE_W(ISSUE_W), .MISS_W(MISS_W), .DOWN_WIN(DW), .UP_WIN(UW),
        .CLK_LEAD(LEAD), .RAMP_CYC(RAMP), .LOW_ILP_MAX(LT), .HIGH_ILP_MIN(HT)
    ) uut (
        .clk(clk), .rst(rst), .miss_det(miss_det), .miss_ret(miss_ret),
        .miss_outstanding(miss_outstanding), .issue_cnt(issue_cnt),
        .supply_low(supply_low), .clk_half(clk_half), .busy(busy)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
    end

    function automatic bit exp_low();
        return (m_st == M_LOW) || (m_st == M_UC) || (m_st == M_RD && m_cnt >= LEAD);
    endfunction
    function automatic bit exp_half();
        return (m_st == M_RD) || (m_st == M_LOW) || (m_st == M_UC) || (m_st == M_RU);
    endfunction
    function automatic bit exp_busy();
        return (m_st == M_RD) || (m_st == M_RU);
    endfunction

    // Reference behaviour derived from the requirements, one clock edge at a time
    task automatic model_step(bit md, bit mr, int outst, int iss);
        case (m_st)
            M_HIGH: if (md) begin m_st = M_DN; m_cnt = 0; m_acc = 0; end
            M_DN: begin
                m_acc += iss; m_cnt++;
                if (m_cnt == DW) begin m_st = (m_acc <= LT) ? M_RD : M_HIGH; m_cnt = 0; end
            end
            M_RD: begin m_cnt++; if (m_cnt == LEAD + RAMP) begin m_st = M_LOW; m_cnt = 0; end end
            M_LOW: if (mr && outst == 1 && !md) begin m_st = M_UC; m_cnt = 0; m_acc = 0; end
            M_UC: begin
                if (md) begin m_st = M_LOW; m_cnt = 0; end
                else begin
                    m_acc += iss; m_cnt++;
                    if (m_cnt == UW) begin m_st = (m_acc >= HT) ? M_RU : M_LOW; m_cnt = 0; end
                end
            end
            default: begin m_cnt++; if (m_cnt == RAMP) begin m_st = M_HIGH; m_cnt = 0; end end
        endcase
    endtask

    task automatic check1(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check1(tag, "supply_low", supply_low, exp_low());
        check1(tag, "clk_half", clk_half, exp_half());
        check1(tag, "busy", busy, exp_busy());
    endtask

    // Drive one cycle of inputs (called at a falling edge), then compare after the next rising edge
    task automatic tick(bit md, bit mr, int outst, int iss, string tag);
        miss_det = md; miss_ret = mr;
        miss_outstanding = MISS_W'(outst); issue_cnt = ISSUE_W'(iss);
        @(negedge clk);
        model_step(md, mr, outst, iss);
        check_all(tag);
    endtask

    task automatic idle(int n, int iss, string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1, iss, tag);
    endtask

    int seed_val;
    bit hi_phase;

    initial begin
        seed_val = $urandom(2024);
        repeat (3) @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // Down path at the exact threshold sum (1+1+1+1 = LT)
        tick(1'b1, 1'b0, 1, 1, "R2");
        for (int i = 0; i < DW; i++) tick(1'b0, 1'b0, 1, 1, "R3");
        for (int i = 0; i < LEAD + RAMP; i++) tick(1'b1, i[0], 1, 0, "R8");
        check1("R4", "supply_low after ramp", supply_low, 1'b1);
        check1("R4", "busy after ramp", busy, 1'b0);
        idle(2, 0, "R4");

        // Return that is not the last: stays low
        tick(1'b0, 1'b1, 2, 7, "R5");
        idle(UW + RAMP + 2, 7, "R5");
        check1("R5", "clk_half still half", clk_half, 1'b1);

        // Last return, sum exactly HT (2*6), ramp up with pulses ignored
        tick(1'b0, 1'b1, 1, 0, "R6");
        idle(UW, 2, "R6");
        for (int i = 0; i < RAMP; i++) tick(i[0], 1'b1, 1, 0, "R8");
        check1("R7", "clk_half after up ramp", clk_half, 1'b0);
        idle(2, 0, "R7");

        // Down check that fails (sum 12 > LT)
        tick(1'b1, 1'b0, 1, 3, "R3");
        idle(DW + LEAD + RAMP, 3, "R3");
        check1("R3", "supply_low stays high", supply_low, 1'b0);

        // Go low again
        tick(1'b1, 1'b0, 1, 0, "R2");
        idle(DW + LEAD + RAMP + 1, 0, "R4");

        // Detect and return in the same cycle: no up window
        tick(1'b1, 1'b1, 1, 7, "R5");
        idle(UW + RAMP + 1, 7, "R5");
        check1("R5", "simultaneous pulses", supply_low, 1'b1);

        // Abort of the up window
        tick(1'b0, 1'b1, 1, 7, "R9");
        idle(2, 7, "R9");
        tick(1'b1, 1'b0, 1, 7, "R9");
        idle(UW + RAMP + 2, 7, "R9");
        check1("R9", "still low after abort", supply_low, 1'b1);

        // Up window with too little activity (sum HT-1)
        tick(1'b0, 1'b1, 1, 0, "R6");
        idle(UW - 1, 2, "R6");
        tick(1'b0, 1'b0, 1, 1, "R6");
        idle(RAMP + 2, 0, "R6");
        check1("R6", "low after failed up window", supply_low, 1'b1);

        // Random traffic with activity phases
        hi_phase = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (i % 50 == 0) hi_phase = ~hi_phase;
            tick(($urandom % 16) == 0, ($urandom % 4) == 0, 1 + ($urandom % 3),
                 hi_phase ? 2 + ($urandom % 6) : ($urandom % 2), "R10");
            check1("R10", "low implies half clock", supply_low && !clk_half, 1'b0);
        end

        summary();
    end
endmodule